// File: doc/BRIEF.md
# Sound-Processor Control Slave

This block is a two-wire serial slave that sits beside a television sound demodulator and holds its control settings. A host addresses it, sends a function byte and a data byte, and the slave updates one of its control latches: the audio output mode, the mute switch, a pair of test bits, a pair of free-running frequency bits and a separation trim code. The latched fields leave the block as plain outputs that steer the analog matrix and trim circuits.

On a read transfer the slave ignores the function byte and then drives a status byte. That byte reports the detected broadcast identification (mono, stereo or bilingual) twice, once as flags and once as their complement, so the host can spot a corrupted transfer.

Both bus lines are sampled against a fast system clock, at least eight times the bus bit rate, through a synchronizer. The data line is modelled as an input plus a pull-low enable. One input pin selects between two device addresses so that two slaves can share a bus.

Top module: `snd_ctl_i2c_slave`

## Requirements
- R1: The 7-bit device address is 1000010b (write byte 84h, read byte 85h) when `addr_sel_low` is 0, and 1000011b (86h, 87h) when it is 1. Any other address byte gets no acknowledge, and no latch changes.
- R2: Every byte the slave receives after a matching address is acknowledged: it pulls SDA low during the ninth clock. The slave changes its SDA drive only while SCL is low.
- R3: A start condition (SDA falling while SCL is high) at any point aborts the current byte, and the next eight bits are taken as a new address byte.
- R4: Function code 000 in the top three bits of the function byte loads the mode field from data bits 7:6 (00 mono, 01 stereo, 10 bilingual, 11 sub).
- R5: Function code 001 loads the mute output from data bit 7, where 1 mutes.
- R6: Function code 010 loads the test bits from data bits 7:6. Function code 011 loads the free-running frequency bits from data bits 7:6.
- R7: Function codes 100 and 101 both load the 5-bit separation trim from data bits 7:3.
- R8: Function codes 110 and 111 are still acknowledged for both the function byte and the data byte, but they change no output.
- R9: After reset the mode is 00, mute is 0, test and frequency bits are 0, and the trim is 10000b.
- R10: After a read address, the slave acknowledges one ignored function byte and then sends the status byte MSB first. Its bits 7:4 are {bilingual, stereo, not bilingual, not stereo} and bits 3:0 are 0. Stereo wins when both flags are set. The encodings are mono 30h, stereo 60h and bilingual 90h.
- R11: During the host's acknowledge slot after a status byte the slave leaves SDA released. A host acknowledge makes it send the status byte again. A not-acknowledge returns it to idle, so it drives nothing on later clocks.
- R12: A stop condition (SDA rising while SCL is high) returns the slave to idle with SDA released. Bytes after the data byte of a write get no acknowledge and no effect.
- R13: Latches change only when the data byte of a matching write completes. A transfer cut short by a start or a stop leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | When 1, the slave pulls the data line low |
| addr_sel_low | input | 1 | Address select: 1 selects device address 1000011b |
| id_stereo | input | 1 | Stereo identification flag from the pilot detector |
| id_bilingual | input | 1 | Bilingual identification flag from the pilot detector |
| mode_sel | output | 2 | Audio mode: 00 mono, 01 stereo, 10 bilingual, 11 sub |
| mute | output | 1 | Audio mute, 1 mutes |
| test_bits | output | TEST_W (2) | Stored test-mode bits |
| freerun_bits | output | FREQ_W (2) | Stored free-running frequency bits |
| sep_trim | output | TRIM_W (5) | Stereo separation trim code |

## Verification
The embedded properties watch, on every cycle, that the latches hold except on a completed write, that codes 110 and 111 leave them alone, and that mode and mute take exactly the written bits. They also check that SDA drive changes only while SCL is low and that the slave is released when idle, during the host acknowledge slot and after a stop. Only the bench scenarios can show that the address decoding follows the select pin, that the status byte encodes each identification combination correctly, that a host acknowledge repeats the byte, and that transfers cut short by a restart or a stop are discarded.

// File: rtl/sndctl_pkg.sv
package sndctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_HACK,
      ST_SKIP
   } eng_state_t;

   typedef enum logic [2:0] {
      FN_MODE = 3'b000,
      FN_MUTE = 3'b001,
      FN_TEST = 3'b010,
      FN_FREQ = 3'b011,
      FN_SEP0 = 3'b100,
      FN_SEP1 = 3'b101,
      FN_RSV0 = 3'b110,
      FN_RSV1 = 3'b111
   } fn_t;

   typedef struct packed {
      logic       en;
      fn_t        fn;
      logic [7:0] data;
   } wr_req_t;

   localparam int unsigned BYTE_BITS = 8;

endpackage

// File: rtl/sndctl_sync.sv
module sndctl_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] q_d
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sndctl_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < W; i++) begin : g_line
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '1;
         else        sh <= {sh[STAGES-2:0], d[i]};
      end
      assign q[i] = sh[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_d <= '1;
      else        q_d <= q;
   end

endmodule

// File: rtl/sndctl_id_enc.sv
module sndctl_id_enc #(
   parameter bit STEREO_FIRST = 1'b1
) (
   input  logic       id_st,
   input  logic       id_bi,
   output logic [7:0] status
);

   logic st_eff;
   logic bi_eff;

   if (STEREO_FIRST) begin : g_st_wins
      assign st_eff = id_st;
      assign bi_eff = id_bi & ~id_st;
   end else begin : g_bi_wins
      assign st_eff = id_st & ~id_bi;
      assign bi_eff = id_bi;
   end

   // flags followed by their complement, low nibble reserved as zero
   assign status = {bi_eff, st_eff, ~bi_eff, ~st_eff, 4'b0000};

endmodule

// File: rtl/sndctl_engine.sv
module sndctl_engine
   import sndctl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_s,
   input  logic       scl_q,
   input  logic       sda_s,
   input  logic       sda_q,
   input  logic [6:0] dev_addr7,
   input  logic [7:0] status,
   output logic       sda_oe,
   output wr_req_t    wr
);

   localparam int unsigned CNT_W = $clog2(BYTE_BITS + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_BITS);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_BITS - 1);

   if (BYTE_BITS != 8) begin : g_bad_byte
      $error("sndctl_engine: byte length must be 8");
   end

   eng_state_t       state;
   logic [CNT_W-1:0] bit_cnt;
   logic [1:0]       byte_idx;
   logic [7:0]       shreg;
   logic [7:0]       tx_q;
   logic             rd_q;
   logic             nack_q;
   logic             sda_oe_q;
   fn_t              sub_fn_q;
   wr_req_t          wr_q;

   logic scl_rise;
   logic scl_fall;
   logic start_evt;
   logic stop_evt;

   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   assign start_evt =  scl_s &  scl_q &  sda_q & ~sda_s;
   assign stop_evt  =  scl_s &  scl_q & ~sda_q &  sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bit_cnt  <= '0;
         byte_idx <= '0;
         shreg    <= '0;
         tx_q     <= '0;
         rd_q     <= 1'b0;
         nack_q   <= 1'b1;
         sda_oe_q <= 1'b0;
         sub_fn_q <= FN_MODE;
         wr_q     <= '0;
      end else begin
         wr_q.en <= 1'b0;
         if (start_evt) begin
            state    <= ST_RX;
            bit_cnt  <= '0;
            byte_idx <= '0;
            rd_q     <= 1'b0;
            sda_oe_q <= 1'b0;
         end else if (stop_evt) begin
            state    <= ST_IDLE;
            sda_oe_q <= 1'b0;
         end else begin
            case (state)
               ST_RX: begin
                  if (scl_rise && bit_cnt != CNT_FULL) begin
                     shreg   <= {shreg[6:0], sda_s};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (scl_fall && bit_cnt == CNT_FULL) begin
                     bit_cnt <= '0;
                     if (byte_idx == 2'd0) begin
                        if (shreg[7:1] == dev_addr7) begin
                           rd_q     <= shreg[0];
                           sda_oe_q <= 1'b1;
                           state    <= ST_ACK;
                        end else begin
                           state <= ST_SKIP;
                        end
                     end else if (byte_idx == 2'd1) begin
                        sub_fn_q <= fn_t'(shreg[7:5]);
                        sda_oe_q <= 1'b1;
                        state    <= ST_ACK;
                     end else begin
                        wr_q     <= '{en: 1'b1, fn: sub_fn_q, data: shreg};
                        sda_oe_q <= 1'b1;
                        state    <= ST_ACK;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     bit_cnt <= '0;
                     if (rd_q && byte_idx == 2'd1) begin
                        tx_q     <= status;
                        sda_oe_q <= ~status[7];
                        state    <= ST_TX;
                     end else if (byte_idx == 2'd2) begin
                        sda_oe_q <= 1'b0;
                        state    <= ST_SKIP;
                     end else begin
                        sda_oe_q <= 1'b0;
                        byte_idx <= byte_idx + 2'd1;
                        state    <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (bit_cnt == CNT_LAST) begin
                        sda_oe_q <= 1'b0;
                        bit_cnt  <= '0;
                        state    <= ST_HACK;
                     end else begin
                        tx_q     <= {tx_q[6:0], 1'b0};
                        sda_oe_q <= ~tx_q[6];
                        bit_cnt  <= bit_cnt + 1'b1;
                     end
                  end
               end
               ST_HACK: begin
                  if (scl_rise) begin
                     nack_q <= sda_s;
                  end else if (scl_fall) begin
                     if (nack_q) begin
                        state <= ST_IDLE;
                     end else begin
                        tx_q     <= status;
                        sda_oe_q <= ~status[7];
                        state    <= ST_TX;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe = sda_oe_q;
   assign wr     = wr_q;

   // R2: drive changes only while the clock line is low
   p_sda_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe_q != $past(sda_oe_q)) |-> (!scl_s || $past(start_evt || stop_evt)));

   // R11: host acknowledge slot is never driven by the slave
   p_hack_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HACK) |-> !sda_oe_q);

   // R12: a stop leaves the slave idle and released
   p_stop_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> (state == ST_IDLE) && !sda_oe_q);

   // R12: idle and skip states drive nothing
   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE || state == ST_SKIP) |-> !sda_oe_q);

endmodule

// File: rtl/sndctl_regs.sv
module sndctl_regs
   import sndctl_pkg::*;
#(
   parameter int unsigned TRIM_W         = 5,
   parameter int unsigned TEST_W         = 2,
   parameter int unsigned FREQ_W         = 2,
   parameter bit          SEP_BOTH_CODES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  wr_req_t           wr,
   output logic [1:0]        mode_sel,
   output logic              mute,
   output logic [TEST_W-1:0] test_bits,
   output logic [FREQ_W-1:0] freerun_bits,
   output logic [TRIM_W-1:0] sep_trim
);

   localparam logic [TRIM_W-1:0] TRIM_RST = TRIM_W'(1) << (TRIM_W - 1);

   if (TRIM_W < 1 || TRIM_W > 8) begin : g_bad_trim
      $error("sndctl_regs: TRIM_W must be 1..8");
   end
   if (TEST_W < 1 || TEST_W > 8) begin : g_bad_test
      $error("sndctl_regs: TEST_W must be 1..8");
   end
   if (FREQ_W < 1 || FREQ_W > 8) begin : g_bad_freq
      $error("sndctl_regs: FREQ_W must be 1..8");
   end

   logic sep_hit;
   logic unused_data;

   if (SEP_BOTH_CODES) begin : g_sep_pair
      assign sep_hit = (wr.fn == FN_SEP0) || (wr.fn == FN_SEP1);
   end else begin : g_sep_single
      assign sep_hit = (wr.fn == FN_SEP0);
   end

   assign unused_data = ^wr.data;

   logic [1:0]        mode_q;
   logic              mute_q;
   logic [TEST_W-1:0] test_q;
   logic [FREQ_W-1:0] freq_q;
   logic [TRIM_W-1:0] trim_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 2'b00;
         mute_q <= 1'b0;
         test_q <= '0;
         freq_q <= '0;
         trim_q <= TRIM_RST;
      end else if (wr.en) begin
         if (sep_hit) trim_q <= wr.data[7 -: TRIM_W];
         case (wr.fn)
            FN_MODE: mode_q <= wr.data[7:6];
            FN_MUTE: mute_q <= wr.data[7];
            FN_TEST: test_q <= wr.data[7 -: TEST_W];
            FN_FREQ: freq_q <= wr.data[7 -: FREQ_W];
            default: ;
         endcase
      end
   end

   assign mode_sel     = mode_q;
   assign mute         = mute_q;
   assign test_bits    = test_q;
   assign freerun_bits = freq_q;
   assign sep_trim     = trim_q;

   // R13: nothing moves without a completed write
   p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !wr.en |=> $stable(mode_q) && $stable(mute_q) && $stable(test_q)
                 && $stable(freq_q) && $stable(trim_q));

   // R8: reserved function codes leave all fields alone
   p_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr.en && wr.fn[2:1] == 2'b11) |=> $stable(mode_q) && $stable(mute_q)
         && $stable(test_q) && $stable(freq_q) && $stable(trim_q));

   // R4: mode write takes data bits 7:6 and spares mute
   p_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr.en && wr.fn == FN_MODE) |=> (mode_q == $past(wr.data[7:6])) && $stable(mute_q));

   // R5: mute write takes data bit 7 and spares mode
   p_mute_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr.en && wr.fn == FN_MUTE) |=> (mute_q == $past(wr.data[7])) && $stable(mode_q));

endmodule

// File: rtl/snd_ctl_i2c_slave.sv
module snd_ctl_i2c_slave
   import sndctl_pkg::*;
#(
   parameter int unsigned SYNC_STAGES    = 2,
   parameter logic [6:0]  BASE_ADDR7     = 7'h42,
   parameter int unsigned TRIM_W         = 5,
   parameter int unsigned TEST_W         = 2,
   parameter int unsigned FREQ_W         = 2,
   parameter bit          SEP_BOTH_CODES = 1'b1,
   parameter bit          STEREO_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic              addr_sel_low,
   input  logic              id_stereo,
   input  logic              id_bilingual,
   output logic [1:0]        mode_sel,
   output logic              mute,
   output logic [TEST_W-1:0] test_bits,
   output logic [FREQ_W-1:0] freerun_bits,
   output logic [TRIM_W-1:0] sep_trim
);

   if (BASE_ADDR7[0] != 1'b0) begin : g_bad_base
      $error("snd_ctl_i2c_slave: BASE_ADDR7 bit 0 is taken by the select pin");
   end

   logic [1:0] line_s;
   logic [1:0] line_q;
   logic [6:0] dev_addr7;
   logic [7:0] status;
   wr_req_t    wr;

   assign dev_addr7 = {BASE_ADDR7[6:1], addr_sel_low};

   sndctl_sync #(
      .STAGES (SYNC_STAGES),
      .W      (2)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     (line_s),
      .q_d   (line_q)
   );

   sndctl_id_enc #(
      .STEREO_FIRST (STEREO_FIRST)
   ) u_id (
      .id_st  (id_stereo),
      .id_bi  (id_bilingual),
      .status (status)
   );

   sndctl_engine u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (line_s[1]),
      .scl_q     (line_q[1]),
      .sda_s     (line_s[0]),
      .sda_q     (line_q[0]),
      .dev_addr7 (dev_addr7),
      .status    (status),
      .sda_oe    (sda_oe),
      .wr        (wr)
   );

   sndctl_regs #(
      .TRIM_W         (TRIM_W),
      .TEST_W         (TEST_W),
      .FREQ_W         (FREQ_W),
      .SEP_BOTH_CODES (SEP_BOTH_CODES)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr           (wr),
      .mode_sel     (mode_sel),
      .mute         (mute),
      .test_bits    (test_bits),
      .freerun_bits (freerun_bits),
      .sep_trim     (sep_trim)
   );

endmodule

// File: tb/snd_ctl_i2c_slave_tb_top.sv
module snd_ctl_i2c_slave_tb_top;

   localparam int Q = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic host_low = 1'b0;
   logic addr_sel_low = 1'b0;
   logic id_st = 1'b0;
   logic id_bi = 1'b0;
   logic sda_oe;
   logic sda_line;
   logic [1:0] mode_sel;
   logic       mute;
   logic [1:0] test_bits;
   logic [1:0] freerun_bits;
   logic [4:0] sep_trim;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [1:0] e_mode = 2'b00;
   logic       e_mute = 1'b0;
   logic [1:0] e_test = 2'b00;
   logic [1:0] e_freq = 2'b00;
   logic [4:0] e_trim = 5'b10000;

   always #4 clk = ~clk;

   assign sda_line = !(host_low || sda_oe);

   snd_ctl_i2c_slave dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_i        (scl),
      .sda_i        (sda_line),
      .sda_oe       (sda_oe),
      .addr_sel_low (addr_sel_low),
      .id_stereo    (id_st),
      .id_bilingual (id_bi),
      .mode_sel     (mode_sel),
      .mute         (mute),
      .test_bits    (test_bits),
      .freerun_bits (freerun_bits),
      .sep_trim     (sep_trim)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic bus_start();
      host_low = 1'b0; wclk(Q);
      scl = 1'b1;      wclk(Q);
      host_low = 1'b1; wclk(Q);
      scl = 1'b0;      wclk(Q);
   endtask

   task automatic bus_stop();
      host_low = 1'b1; wclk(Q);
      scl = 1'b1;      wclk(Q);
      host_low = 1'b0; wclk(2 * Q);
   endtask

   task automatic put_bit(input logic b);
      host_low = !b; wclk(Q);
      scl = 1'b1;    wclk(2 * Q);
      scl = 1'b0;    wclk(Q);
   endtask

   task automatic get_bit(output logic b);
      host_low = 1'b0; wclk(Q);
      scl = 1'b1;      wclk(Q);
      b = sda_line;    wclk(Q);
      scl = 1'b0;      wclk(Q);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(b);
      ack = !b;
   endtask

   task automatic recv_byte(output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
   endtask

   task automatic model_write(input logic [7:0] sub, input logic [7:0] d);
      case (sub[7:5])
         3'd0: e_mode = d[7:6];
         3'd1: e_mute = d[7];
         3'd2: e_test = d[7:6];
         3'd3: e_freq = d[7:6];
         3'd4, 3'd5: e_trim = d[7:3];
         default: ;
      endcase
   endtask

   task automatic chk_all(input string req);
      chk({req, " mode"}, mode_sel, e_mode);
      chk({req, " mute"}, mute, e_mute);
      chk({req, " test"}, test_bits, e_test);
      chk({req, " freq"}, freerun_bits, e_freq);
      chk({req, " trim"}, sep_trim, e_trim);
   endtask

   function automatic logic [7:0] exp_status(input logic st, input logic bi);
      logic b;
      b = bi & ~st;
      return {b, st, ~b, ~st, 4'b0000};
   endfunction

   function automatic logic [7:0] dev_w();
      return addr_sel_low ? 8'h86 : 8'h84;
   endfunction

   task automatic full_write(input logic [7:0] sub, input logic [7:0] d, input string req);
      logic a;
      bus_start();
      send_byte(dev_w(), a);
      chk({req, " addr ack"}, a, 1);
      send_byte(sub, a);
      chk({req, " R2 sub ack"}, a, 1);
      send_byte(d, a);
      chk({req, " R2 data ack"}, a, 1);
      bus_stop();
      model_write(sub, d);
   endtask

   initial begin
      logic       a;
      logic       b;
      logic [7:0] rb;
      logic [7:0] ad;
      logic [7:0] d;
      wclk(5);
      rst_n = 1'b1;
      wclk(5);

      // reset state
      chk_all("R9 reset");
      chk("R12 idle release", sda_oe, 0);

      // address sweep across both select settings
      for (int s = 0; s < 2; s++) begin
         addr_sel_low = s[0];
         for (int i = 0; i < 16; i++) begin
            ad = 8'h80 + 8'(i);
            bus_start();
            send_byte(ad, a);
            chk("R1 address ack", a, (ad[7:1] == {6'b100001, s[0]}) ? 1 : 0);
            if (a && ad[0]) begin
               send_byte(8'h00, b);
               recv_byte(rb);
               chk("R10 status on sweep", rb, 8'h30);
               put_bit(1'b1);
            end else if (a) begin
               d = {2'(i + s), 6'b000111};
               send_byte(8'h00, b);
               send_byte(d, b);
               model_write(8'h00, d);
            end else begin
               d = {2'(i + 1), 6'b0};
               send_byte(8'h00, b);
               chk("R1 mismatch no ack", b, 0);
            end
            bus_stop();
            chk("R1 mode after address", mode_sel, e_mode);
         end
      end
      addr_sel_low = 1'b0;

      // every function code with several data patterns
      for (int f = 0; f < 8; f++) begin
         for (int k = 0; k < 4; k++) begin
            d = 8'((k * 91 + f * 39 + 17) & 255);
            full_write({3'(f), 5'b10101}, d, f >= 6 ? "R8" : "R4-7");
            chk_all(f == 0 ? "R4" : f == 1 ? "R5" : f < 4 ? "R6" : f < 6 ? "R7" : "R8");
         end
      end

      // bytes past the data byte are not acknowledged
      bus_start();
      send_byte(8'h84, a);
      send_byte(8'h20, a);
      send_byte(8'h80, a);
      model_write(8'h20, 8'h80);
      send_byte(8'h00, a);
      chk("R12 extra byte no ack", a, 0);
      bus_stop();
      chk_all("R12 extra byte");

      // restart in the middle of the function byte
      bus_start();
      send_byte(8'h84, a);
      put_bit(1'b0); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
      bus_start();
      chk_all("R13 after restart");
      send_byte(8'h84, a);
      chk("R3 restart address ack", a, 1);
      send_byte(8'h00, a);
      send_byte(8'hC0, a);
      model_write(8'h00, 8'hC0);
      bus_stop();
      chk_all("R3 write after restart");

      // stop after the function byte and mid data byte
      bus_start();
      send_byte(8'h84, a);
      send_byte(8'h00, a);
      bus_stop();
      chk_all("R13 stop after function byte");
      bus_start();
      send_byte(8'h84, a);
      send_byte(8'h20, a);
      put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
      bus_stop();
      chk_all("R13 stop inside data byte");

      // reads for every flag combination
      for (int fl = 0; fl < 4; fl++) begin
         id_st = fl[0];
         id_bi = fl[1];
         wclk(4);
         bus_start();
         send_byte(8'h85, a);
         chk("R10 read address ack", a, 1);
         send_byte(8'h20, a);
         chk("R10 ignored byte ack", a, 1);
         recv_byte(rb);
         chk("R10 status byte", rb, exp_status(id_st, id_bi));
         put_bit(1'b0);
         recv_byte(rb);
         chk("R11 repeated status", rb, exp_status(id_st, id_bi));
         put_bit(1'b1);
         get_bit(b);
         chk("R11 released after nack", b, 1);
         bus_stop();
         chk_all("R10 read leaves latches");
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog all requirements actual=timeout expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule